// File: doc/BRIEF.md
# Time-Sliced Event Counter Unit

This block counts micro-architectural events for performance analysis. A small set of physical counters covers a longer list of programmable events by time-slicing. Four counters are fixed. Counter 0 counts clock cycles while counting is on, and the other three follow dedicated pulse inputs. Four further lanes take their event from a selectable source, and these lanes rotate through a table of event groups. Each group names four events, and the unit moves to the next group after a programmable number of cycles.

For every table slot (one group and one lane), the unit keeps a raw event count and a running time. The running time is the number of counting cycles in which that slot held a physical counter. A single enabled-time counter records how many cycles monitoring was on, and every slot shares it. Software extrapolates a slot's total as raw × enabled / running, and the division is done in software.

The group table, the group count and the slice length are written over a single-cycle register port, and all counters are read back over the same port. A no-rotation mode pins the lanes to group 0. Separate inputs start counting, stop it and clear the counters.

Top module: `evmux_pmu`

## Requirements
- R1: While counting is on, fixed counter 0 increments every cycle. Fixed counter k (k = 1..3) increments in each counting cycle where `fix_evt_i[k-1]` is high. Fixed counter k reads at region 3, sub-address k.
- R2: The enabled-time counter increments in every counting cycle and reads at region 3, sub-address 4.
- R3: In a counting cycle, only the four slots of the active group count. Slot (g, l) adds 1 when `evt_i[sel]` is high, where sel is bits [6l+5:6l] of table entry g. All other slots hold their value. The raw count of slot s = 4g+l reads at region 1, sub-address s.
- R4: The running time of a slot increments in each counting cycle in which its group is active. It reads at region 2, sub-address s.
- R5: With slice value L, each group stays active for max(L,1) counting cycles. The switch takes effect on the cycle after the slice counter reaches zero. The group index then wraps from the last valid group to 0. The last valid group is N−1 for a group count N of 1..16; a count of 0 gives a single group and a count above 16 gives 16. The active group reads at region 3, sub-address 5 and on `grp_o`.
- R6: While `nomux_i` is high, group 0 is active, rotation is frozen, and the slice counter is reloaded on every counting cycle.
- R7: Every raw, running, fixed and enabled counter saturates at its all-ones value instead of wrapping.
- R8: A pulse on `start_i` turns counting on from the next cycle. A pulse on `stop_i` turns it off, and stop wins if both are high. While counting is off, no counter, slice counter or group index changes. `running_o` shows the state.
- R9: A `clear_i` pulse zeroes every counter, returns the group index to 0 and reloads the slice counter. No event is counted in that cycle, and the run state is unchanged.
- R10: The register address is {region[1:0], sub[5:0]}. In region 0, sub 0..15 is table entry g, holding four 6-bit selects with lane 0 in bits [5:0]. Sub 16 is the group count in bits [4:0] and sub 17 is the slice length in bits [15:0]. A write lands on the next edge and is read back from the same address. Unmapped reads return 0.
- R11: After reset, counting is off, group 0 is active, all counters and table entries are 0, the group count is 1 and the slice length is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Turn counting on |
| stop_i | input | 1 | Turn counting off |
| clear_i | input | 1 | Zero counters, restart rotation |
| nomux_i | input | 1 | Hold lanes on group 0, no rotation |
| fix_evt_i | input | 3 | Pulses for fixed counters 1..3 |
| evt_i | input | 64 | Per-cycle event pulses, indexed by select code |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address {region, sub} |
| reg_wdata_i | input | 24 | Register write data |
| reg_rdata_o | output | 48 | Combinational read data |
| running_o | output | 1 | Counting is on |
| grp_o | output | 4 | Active group index |

## Verification
The checker assumes that the control pulses are synchronous, one-cycle strobes. It also assumes that `nomux_i` changes only while counting is off or together with a clear, so that its properties on frozen groups describe intended use. The bench follows these rules: it changes controls only at the falling edge and drops every pulse after one cycle. It writes the group table and slice length only while counting is off, then issues a clear before restarting, so each run begins from a freshly loaded slice. The bench builds the block with narrow counters, so saturation is reached within a short run.

// File: rtl/evmux_pkg.sv
package evmux_pkg;
  typedef enum logic [1:0] {
    RG_CFG  = 2'd0,
    RG_RAW  = 2'd1,
    RG_RUN  = 2'd2,
    RG_MISC = 2'd3
  } rg_e;
endpackage

// File: rtl/evmux_cfg.sv
module evmux_cfg
  import evmux_pkg::*;
#(
  parameter int N_GRP   = 16,
  parameter int SLICE_W = 16,
  parameter int SLOT_W  = 6,
  parameter int WD_W    = 24,
  parameter int GRP_W   = 4,
  parameter int NG_W    = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  rg_e                         rg_i,
  input  logic [SLOT_W-1:0]           sub_i,
  input  logic [WD_W-1:0]             wdata_i,
  output logic [N_GRP-1:0][WD_W-1:0]  tbl_o,
  output logic [NG_W-1:0]             ng_o,
  output logic [SLICE_W-1:0]          slice_o,
  output logic [GRP_W-1:0]            last_o,
  output logic [SLICE_W-1:0]          sload_o
);
  logic cfg_we;
  assign cfg_we = we_i && (rg_i == RG_CFG);

  for (genvar g = 0; g < N_GRP; g++) begin : g_tbl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                tbl_o[g] <= '0;
      else if (cfg_we && sub_i == SLOT_W'(g))     tbl_o[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ng_o    <= NG_W'(1);
      slice_o <= '0;
    end else if (cfg_we) begin
      if (sub_i == SLOT_W'(N_GRP))     ng_o    <= wdata_i[NG_W-1:0];
      if (sub_i == SLOT_W'(N_GRP + 1)) slice_o <= wdata_i[SLICE_W-1:0];
    end
  end

  // count of 0 means one group; counts beyond the table clamp
  always_comb begin
    if (ng_o == '0)                 last_o = '0;
    else if (ng_o > NG_W'(N_GRP))   last_o = GRP_W'(N_GRP - 1);
    else                            last_o = GRP_W'(ng_o - NG_W'(1));
  end

  assign sload_o = (slice_o == '0) ? '0 : slice_o - SLICE_W'(1);
endmodule

// File: rtl/evmux_sched.sv
module evmux_sched #(
  parameter int SLICE_W = 16,
  parameter int GRP_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               clear_i,
  input  logic               nomux_i,
  input  logic [GRP_W-1:0]   last_i,
  input  logic [SLICE_W-1:0] sload_i,
  output logic               run_o,
  output logic [GRP_W-1:0]   cur_o,
  output logic [GRP_W-1:0]   act_o,
  output logic [SLICE_W-1:0] scnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_o <= 1'b0;
    else if (stop_i)  run_o <= 1'b0;
    else if (start_i) run_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o  <= '0;
      scnt_o <= '0;
    end else if (clear_i) begin
      cur_o  <= '0;
      scnt_o <= sload_i;
    end else if (run_o) begin
      if (nomux_i) begin
        scnt_o <= sload_i;
      end else if (scnt_o == '0) begin
        // >= also covers a group count shrunk below the current index
        cur_o  <= (cur_o >= last_i) ? '0 : cur_o + GRP_W'(1);
        scnt_o <= sload_i;
      end else begin
        scnt_o <= scnt_o - SLICE_W'(1);
      end
    end
  end

  assign act_o = nomux_i ? '0 : cur_o;
endmodule

// File: rtl/evmux_bank.sv
module evmux_bank #(
  parameter int N_GRP  = 16,
  parameter int N_CFG  = 4,
  parameter int SEL_W  = 6,
  parameter int CNT_W  = 48,
  parameter int N_FIX  = 4,
  parameter int GRP_W  = 4,
  parameter int WD_W   = 24,
  localparam int N_EVT  = 1 << SEL_W,
  localparam int N_SLOT = N_GRP * N_CFG
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        run_i,
  input  logic                        clear_i,
  input  logic [GRP_W-1:0]            act_i,
  input  logic [N_GRP-1:0][WD_W-1:0]  tbl_i,
  input  logic [N_EVT-1:0]            evt_i,
  input  logic [N_FIX-2:0]            fix_evt_i,
  output logic [N_SLOT-1:0][CNT_W-1:0] raw_o,
  output logic [N_SLOT-1:0][CNT_W-1:0] runt_o,
  output logic [N_FIX-1:0][CNT_W-1:0]  fix_o,
  output logic [CNT_W-1:0]             en_o
);
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v, input logic b);
    if (b && (v != {CNT_W{1'b1}})) return v + CNT_W'(1);
    return v;
  endfunction

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic live;
    assign live = run_i && (act_i == GRP_W'(g));
    for (genvar l = 0; l < N_CFG; l++) begin : g_lane
      localparam int S = g * N_CFG + l;
      logic [SEL_W-1:0] sel;
      logic             hit;
      assign sel = tbl_i[g][l*SEL_W +: SEL_W];
      assign hit = evt_i[sel];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          raw_o[S]  <= '0;
          runt_o[S] <= '0;
        end else if (clear_i) begin
          raw_o[S]  <= '0;
          runt_o[S] <= '0;
        end else if (live) begin
          raw_o[S]  <= sat_inc(raw_o[S], hit);
          runt_o[S] <= sat_inc(runt_o[S], 1'b1);
        end
      end
    end
  end

  for (genvar f = 0; f < N_FIX; f++) begin : g_fix
    logic inc;
    if (f == 0) begin : g_cyc
      assign inc = 1'b1;
    end else begin : g_pin
      assign inc = fix_evt_i[f-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      fix_o[f] <= '0;
      else if (clear_i) fix_o[f] <= '0;
      else if (run_i)   fix_o[f] <= sat_inc(fix_o[f], inc);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (clear_i) en_o <= '0;
    else if (run_i)   en_o <= sat_inc(en_o, 1'b1);
  end
endmodule

// File: rtl/evmux_pmu.sv
module evmux_pmu
  import evmux_pkg::*;
#(
  parameter int N_GRP   = 16,
  parameter int N_CFG   = 4,
  parameter int N_FIX   = 4,
  parameter int SEL_W   = 6,
  parameter int CNT_W   = 48,
  parameter int SLICE_W = 16,
  localparam int N_EVT  = 1 << SEL_W,
  localparam int GRP_W  = $clog2(N_GRP),
  localparam int NG_W   = $clog2(N_GRP + 1),
  localparam int SLOT_W = $clog2(N_GRP * N_CFG),
  localparam int AW     = SLOT_W + 2,
  localparam int WD_W   = N_CFG * SEL_W,
  localparam int RD_W   = (CNT_W > WD_W) ? CNT_W : WD_W,
  localparam int FIX_W  = $clog2(N_FIX),
  localparam int N_SLOT = N_GRP * N_CFG
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               clear_i,
  input  logic               nomux_i,
  input  logic [N_FIX-2:0]   fix_evt_i,
  input  logic [N_EVT-1:0]   evt_i,
  input  logic               reg_we_i,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic [WD_W-1:0]    reg_wdata_i,
  output logic [RD_W-1:0]    reg_rdata_o,
  output logic               running_o,
  output logic [GRP_W-1:0]   grp_o
);
  rg_e                          rg;
  logic [SLOT_W-1:0]            sub;
  logic [N_GRP-1:0][WD_W-1:0]   tbl;
  logic [NG_W-1:0]              ng;
  logic [SLICE_W-1:0]           slice_len, sload, slice_cnt;
  logic [GRP_W-1:0]             last_grp, cur_grp, act_grp;
  logic                         run_q;
  logic [N_SLOT-1:0][CNT_W-1:0] raw, runt;
  logic [N_FIX-1:0][CNT_W-1:0]  fix;
  logic [CNT_W-1:0]             en_cnt;

  assign rg  = rg_e'(reg_addr_i[AW-1 -: 2]);
  assign sub = reg_addr_i[SLOT_W-1:0];

  evmux_cfg #(
    .N_GRP(N_GRP), .SLICE_W(SLICE_W), .SLOT_W(SLOT_W),
    .WD_W(WD_W), .GRP_W(GRP_W), .NG_W(NG_W)
  ) u_cfg (
    .clk_i, .rst_ni, .we_i(reg_we_i), .rg_i(rg), .sub_i(sub),
    .wdata_i(reg_wdata_i), .tbl_o(tbl), .ng_o(ng), .slice_o(slice_len),
    .last_o(last_grp), .sload_o(sload)
  );

  evmux_sched #(.SLICE_W(SLICE_W), .GRP_W(GRP_W)) u_sched (
    .clk_i, .rst_ni, .start_i, .stop_i, .clear_i, .nomux_i,
    .last_i(last_grp), .sload_i(sload), .run_o(run_q),
    .cur_o(cur_grp), .act_o(act_grp), .scnt_o(slice_cnt)
  );

  evmux_bank #(
    .N_GRP(N_GRP), .N_CFG(N_CFG), .SEL_W(SEL_W), .CNT_W(CNT_W),
    .N_FIX(N_FIX), .GRP_W(GRP_W), .WD_W(WD_W)
  ) u_bank (
    .clk_i, .rst_ni, .run_i(run_q), .clear_i, .act_i(act_grp),
    .tbl_i(tbl), .evt_i, .fix_evt_i, .raw_o(raw), .runt_o(runt),
    .fix_o(fix), .en_o(en_cnt)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (rg)
      RG_CFG: begin
        if (sub < SLOT_W'(N_GRP))           reg_rdata_o = RD_W'(tbl[sub[GRP_W-1:0]]);
        else if (sub == SLOT_W'(N_GRP))     reg_rdata_o = RD_W'(ng);
        else if (sub == SLOT_W'(N_GRP + 1)) reg_rdata_o = RD_W'(slice_len);
      end
      RG_RAW: reg_rdata_o = RD_W'(raw[sub]);
      RG_RUN: reg_rdata_o = RD_W'(runt[sub]);
      RG_MISC: begin
        if (sub < SLOT_W'(N_FIX))           reg_rdata_o = RD_W'(fix[sub[FIX_W-1:0]]);
        else if (sub == SLOT_W'(N_FIX))     reg_rdata_o = RD_W'(en_cnt);
        else if (sub == SLOT_W'(N_FIX + 1)) reg_rdata_o = RD_W'(act_grp);
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign running_o = run_q;
  assign grp_o     = act_grp;
endmodule

// File: rtl/evmux_pmu_chk.sv
module evmux_pmu_chk #(
  parameter int CNT_W   = 48,
  parameter int GRP_W   = 4,
  parameter int SLICE_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               stop_i,
  input logic               clear_i,
  input logic               nomux_i,
  input logic               running_o,
  input logic [GRP_W-1:0]   cur_grp,
  input logic [SLICE_W-1:0] slice_cnt,
  input logic [CNT_W-1:0]   en_cnt
);
  AST_RUN_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i && !stop_i) |-> running_o);                                   // R8
  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i) |-> !running_o);                                              // R8
  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(running_o) && !$past(clear_i)) |-> ($stable(en_cnt) && $stable(cur_grp) && $stable(slice_cnt))); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> (en_cnt == '0 && cur_grp == '0));                        // R9
  AST_EN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(running_o) && !$past(clear_i) && $past(en_cnt) != {CNT_W{1'b1}})
      |-> en_cnt == CNT_W'($past(en_cnt) + CNT_W'(1)));                         // R2
  AST_EN_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_cnt) == {CNT_W{1'b1}} && !$past(clear_i)) |-> en_cnt == {CNT_W{1'b1}}); // R7
  AST_GRP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clear_i) && $past(slice_cnt) != '0) |-> $stable(cur_grp));          // R5
  AST_NOMUX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(nomux_i) && !$past(clear_i)) |-> $stable(cur_grp));                  // R6
endmodule

bind evmux_pmu evmux_pmu_chk #(.CNT_W(CNT_W), .GRP_W(GRP_W), .SLICE_W(SLICE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .clear_i(clear_i), .nomux_i(nomux_i), .running_o(running_o),
  .cur_grp(cur_grp), .slice_cnt(slice_cnt), .en_cnt(en_cnt)
);

// File: tb/evmux_pmu_bench.sv
`timescale 1ns/1ps
module evmux_pmu_bench;
  localparam int CW   = 10;
  localparam int MAXV = (1 << CW) - 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 0, stop = 0, clear = 0, nomux = 0, we = 0;
  logic [2:0]  fix_evt = '0;
  logic [63:0] evt = '0;
  logic [7:0]  addr = '0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic        running;
  logic [3:0]  grp;

  int n_chk = 0, n_bad = 0;
  bit done = 0, sweep = 1;

  always #2.5 clk = ~clk;

  evmux_pmu #(.CNT_W(CW)) u_evmux_pmu (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .clear_i(clear), .nomux_i(nomux), .fix_evt_i(fix_evt), .evt_i(evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .running_o(running), .grp_o(grp)
  );

  // reference model
  int m_raw[64], m_run[64], m_fix[4], m_tbl[16][4];
  int m_en, m_cur, m_scnt, m_ng, m_slice;
  bit m_on;

  function automatic int sat(int v, int b);
    return (v + b > MAXV) ? MAXV : v + b;
  endfunction
  function automatic int m_last();
    if (m_ng == 0) return 0;
    if (m_ng > 16) return 15;
    return m_ng - 1;
  endfunction
  function automatic int m_act();
    return nomux ? 0 : m_cur;
  endfunction

  task automatic m_reset();
    foreach (m_raw[i]) begin m_raw[i] = 0; m_run[i] = 0; end
    foreach (m_fix[i]) m_fix[i] = 0;
    foreach (m_tbl[g, l]) m_tbl[g][l] = 0;
    m_en = 0; m_cur = 0; m_scnt = 0; m_ng = 1; m_slice = 0; m_on = 0;
  endtask

  task automatic m_step();
    int a, ld, lg;
    a  = m_act();
    ld = (m_slice == 0) ? 0 : m_slice - 1;
    lg = m_last();
    if (clear) begin
      foreach (m_raw[i]) begin m_raw[i] = 0; m_run[i] = 0; end
      foreach (m_fix[i]) m_fix[i] = 0;
      m_en = 0; m_cur = 0; m_scnt = ld;
    end else if (m_on) begin
      for (int l = 0; l < 4; l++) begin
        m_raw[a*4+l] = sat(m_raw[a*4+l], int'(evt[m_tbl[a][l]]));
        m_run[a*4+l] = sat(m_run[a*4+l], 1);
      end
      m_fix[0] = sat(m_fix[0], 1);
      for (int k = 1; k < 4; k++) m_fix[k] = sat(m_fix[k], int'(fix_evt[k-1]));
      m_en = sat(m_en, 1);
      if (nomux) m_scnt = ld;
      else if (m_scnt == 0) begin
        m_cur  = (m_cur >= lg) ? 0 : m_cur + 1;
        m_scnt = ld;
      end else m_scnt--;
    end
    if (we && addr[7:6] == 2'd0) begin
      if (addr[5:0] < 16)
        for (int l = 0; l < 4; l++) m_tbl[addr[3:0]][l] = int'(wdata[l*6 +: 6]);
      else if (addr[5:0] == 16) m_ng = int'(wdata[4:0]);
      else if (addr[5:0] == 17) m_slice = int'(wdata[15:0]);
    end
    if (stop) m_on = 0;
    else if (start) m_on = 1;
  endtask

  function automatic int exp_rd(logic [7:0] a, output string tag);
    int s = int'(a[5:0]);
    tag = "R10";
    case (a[7:6])
      2'd0: begin
        if (s < 16) return m_tbl[s][0] | (m_tbl[s][1] << 6) | (m_tbl[s][2] << 12) | (m_tbl[s][3] << 18);
        if (s == 16) return m_ng;
        if (s == 17) return m_slice;
        return 0;
      end
      2'd1: begin tag = "R3"; return m_raw[s]; end
      2'd2: begin tag = "R4"; return m_run[s]; end
      default: begin
        if (s < 4)  begin tag = "R1"; return m_fix[s]; end
        if (s == 4) begin tag = "R2"; return m_en; end
        if (s == 5) begin tag = "R5"; return m_act(); end
        return 0;
      end
    endcase
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  // compare on every clock, after the edge settles
  always @(posedge clk) begin
    string tg;
    int e;
    #1;
    if (rst_n && !done) begin
      e = exp_rd(addr, tg);
      chk(tg, int'(rdata), e);
      chk("R8", int'(running), int'(m_on));
      chk(nomux ? "R6" : "R5", int'(grp), m_act());
    end
  end

  task automatic tick();
    @(negedge clk);
    evt = {$urandom, $urandom};
    fix_evt = 3'($urandom);
    if (sweep) addr = 8'($urandom);
    start = 0; stop = 0; clear = 0; we = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [23:0] d);
    tick(); we = 1; addr = a; wdata = d;
  endtask

  task automatic peek(string tag, logic [7:0] a, int exp);
    sweep = 0; tick(); addr = a; #1;
    chk(tag, int'(rdata), exp);
    sweep = 1;
  endtask

  task automatic pulse_start(); tick(); start = 1; endtask
  task automatic pulse_stop();  tick(); stop = 1;  endtask
  task automatic pulse_clear(); tick(); clear = 1; endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int frz;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    peek("R11", 8'hC0, 0);
    peek("R11", 8'hC5, 0);
    peek("R11", 8'h10, 1);
    peek("R11", 8'h11, 0);
    peek("R11", 8'h40, 0);
    chk("R11", int'(running), 0);

    // three groups, slice of five cycles
    for (int g = 0; g < 3; g++)
      wr(8'(g), {6'(g*16+3), 6'(g*16+2), 6'(g*16+1), 6'(g*16)});
    wr(8'h10, 24'd3);
    wr(8'h11, 24'd5);
    peek("R10", 8'h01, int'({6'd19, 6'd18, 6'd17, 6'd16}));
    peek("R10", 8'h3F, 0);
    pulse_clear();
    pulse_start();
    repeat (300) tick();

    // stop and stay idle: everything frozen
    pulse_stop();
    tick();
    frz = m_en;
    repeat (40) tick();
    peek("R8", 8'hC4, frz);
    chk("R8", int'(running), 0);

    // start and stop together: stop wins
    tick(); start = 1; stop = 1;
    tick();
    chk("R8", int'(running), 0);

    // no rotation mode
    pulse_clear();
    tick(); nomux = 1;
    pulse_start();
    repeat (120) tick();
    chk("R6", int'(grp), 0);
    peek("R6", 8'h84, 0);
    pulse_stop();
    tick(); nomux = 0;

    // clear while stopped
    pulse_clear();
    peek("R9", 8'hC4, 0);
    peek("R9", 8'hC0, 0);
    peek("R9", 8'h40, 0);

    // full table, clamped group count, one-cycle slices
    for (int g = 0; g < 16; g++)
      wr(8'(g), {6'(g*4+3), 6'(g*4+2), 6'(g*4+1), 6'(g*4)});
    wr(8'h10, 24'd20);
    wr(8'h11, 24'd0);
    pulse_clear();
    pulse_start();
    repeat (100) tick();
    // clear while running keeps the run state
    pulse_clear();
    tick();
    chk("R9", int'(running), 1);
    repeat (1200) tick();
    peek("R7", 8'hC0, MAXV);
    peek("R7", 8'hC4, MAXV);

    // group count of zero: single group
    pulse_stop();
    wr(8'h10, 24'd0);
    wr(8'h11, 24'd3);
    pulse_clear();
    pulse_start();
    repeat (60) tick();
    chk("R5", int'(grp), 0);
    peek("R4", 8'h84, 0);

    pulse_stop();
    repeat (3) tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule